// File: doc/BRIEF.md
# Permutation-Ring Bank Selector

This block sits in a DRAM cache controller and decides which physical bank serves a request. A region number is cut out of the line address. Its upper bits pick a row of a small constant table, and its lower bits pick a slot in that row. Each row lists every bank once, in a scrambled order. So each super-region of the address space owns one slice of every bank.

A vector of powered banks comes in with the request. If the bank in the home slot is powered, that bank is the answer. If it is off, the block walks forward through the same row from the home slot and takes the first powered bank it meets. When the walk passes the last slot, it wraps to slot 0 of that same row. It never borrows from a neighbouring row. A bank that is switched off therefore spreads its regions over several survivors, because the survivor depends on the row. Regions whose home bank is still powered keep their bank.

The answer is registered and appears one clock after the request. A small state register records the outcome of the last cycle:
- `ST_IDLE`: no request was sampled.
- `ST_HIT`: a powered bank was found.
- `ST_EMPTY`: no bank is powered.

Each cycle the register moves into one of these states, chosen only by that cycle's request and search result. `ST_IDLE` is the reset state.

Top module: `bank_steer_top`

## Requirements
- R1: The region number is `req_addr[REGION_LSB+7:REGION_LSB]` (8 bits by default). Its upper 5 bits select the table row and its lower 3 bits select the home slot. Other address bits have no effect on the result.
- R2: When the home-slot bank is powered, the answer is the bank stored at that row and slot. Row r, slot s occupies bits `[(r*8+s)*3 +: 3]` of the `TABLE` parameter, and `req_active[b]=1` means bank b is powered.
- R3: When the home-slot bank is off, the answer is the first powered bank at slots home+1, home+2, and so on. The walk wraps from slot 7 to slot 0 of the same row.
- R4: Whenever `rsp_hit` is high, `rsp_bank` names a bank that was powered in the sampled request.
- R5: `rsp_vld` is high in exactly the cycle after a cycle in which `req_vld` was sampled high.
- R6: A request with `req_active` all zero produces `rsp_vld=1`, `rsp_hit=0` and `rsp_bank=0`.
- R7: In a cycle with no response, `rsp_vld`, `rsp_hit` and `rsp_bank` are all zero.
- R8: While `rst_n` is low, all outputs are zero and requests are not answered.
- R9: In the default table, every row contains each of the 8 banks exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Physical line address |
| req_active | input | NUM_BANKS | Powered-bank vector, one bit per bank |
| rsp_vld | output | 1 | A response is present |
| rsp_hit | output | 1 | A powered bank was found |
| rsp_bank | output | BANK_W | Selected bank, zero when there is no hit |

## Verification
The main instance is built with 8 banks, 32 rows, a 40-bit address and `REGION_LSB=6`. Its `TABLE` is overridden with a permutation set computed by the bench. This lets the bench model predict the answer for each of the 256 regions under all 255 non-empty powered vectors, so every wrap position of the ring walk is reached. A second instance keeps the default table and is swept row by row with all banks powered, to confirm that each row is a full permutation. Random address bits outside the region field, idle gaps and empty vectors cover the slice, timing and no-bank cases.

// File: rtl/bsel_pkg.sv
package bsel_pkg;

    localparam int MAX_TBL_W = 4096;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HIT   = 2'd1,
        ST_EMPTY = 2'd2
    } sel_state_e;

    // Row r, slot s: ((s ^ x_r) * m_r + 3r) mod banks.
    // An odd multiplier and an xor with a constant are both bijections
    // modulo a power of two, so every row is a permutation.
    function automatic logic [MAX_TBL_W-1:0] default_table(input int rows,
                                                           input int banks,
                                                           input int bw);
        logic [MAX_TBL_W-1:0] t;
        int mult [4];
        mult = '{1, 3, 5, 7};
        t = '0;
        for (int r = 0; r < rows; r++) begin
            for (int s = 0; s < banks; s++) begin
                int v;
                v = (((s ^ ((r >> 2) & (banks - 1))) * mult[r % 4]) + r * 3) % banks;
                for (int b = 0; b < bw; b++) begin
                    t[(r * banks + s) * bw + b] = v[b];
                end
            end
        end
        return t;
    endfunction

endpackage

// File: rtl/bsel_row_rom.sv
module bsel_row_rom #(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 3,
    parameter int ROW_W     = 5,
    parameter int TBL_W     = 768,
    parameter logic [TBL_W-1:0] TABLE = '0
) (
    input  logic [ROW_W-1:0]                  row_idx,
    output logic [NUM_BANKS-1:0][BANK_W-1:0]  row_banks
);
    localparam int ROW_BITS = NUM_BANKS * BANK_W;

    always_comb begin
        row_banks = TABLE[row_idx * ROW_BITS +: ROW_BITS];
    end
endmodule

// File: rtl/bsel_ring_pick.sv
module bsel_ring_pick #(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 3
) (
    input  logic [NUM_BANKS-1:0][BANK_W-1:0] row_banks,
    input  logic [BANK_W-1:0]                home_slot,
    input  logic [NUM_BANKS-1:0]             active,
    output logic                             found,
    output logic [BANK_W-1:0]                bank
);
    logic [NUM_BANKS-1:0][BANK_W-1:0] cand;
    logic [NUM_BANKS-1:0]             cand_on;

    // Candidate k sits k slots after home; the slot index wraps modulo
    // NUM_BANKS (a power of two), so the walk stays inside the row.
    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_off
        logic [BANK_W-1:0] slot_k;
        assign slot_k     = home_slot + BANK_W'(k);
        assign cand[k]    = row_banks[slot_k];
        assign cand_on[k] = active[cand[k]];
    end

    always_comb begin
        found = |cand_on;
        bank  = '0;
        for (int k = NUM_BANKS - 1; k >= 0; k--) begin
            if (cand_on[k]) begin
                bank = cand[k];
            end
        end
    end
endmodule

// File: rtl/bank_steer_top.sv
module bank_steer_top #(
    parameter int NUM_BANKS  = 8,
    parameter int NUM_ROWS   = 32,
    parameter int ADDR_W     = 40,
    parameter int REGION_LSB = 6,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int ROW_W     = $clog2(NUM_ROWS),
    localparam int TBL_W     = NUM_ROWS * NUM_BANKS * BANK_W,
    parameter logic [TBL_W-1:0] TABLE =
        TBL_W'(bsel_pkg::default_table(NUM_ROWS, NUM_BANKS, BANK_W))
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_vld,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [NUM_BANKS-1:0] req_active,
    output logic                 rsp_vld,
    output logic                 rsp_hit,
    output logic [BANK_W-1:0]    rsp_bank
);
    import bsel_pkg::*;

    localparam int REGION_W = ROW_W + BANK_W;
    localparam logic [ADDR_W-1:0] REGION_MASK =
        ADDR_W'(((64'd1 << REGION_W) - 64'd1) << REGION_LSB);

    logic [REGION_W-1:0]              region;
    logic [ROW_W-1:0]                 row_idx;
    logic [BANK_W-1:0]                home_slot;
    logic [NUM_BANKS-1:0][BANK_W-1:0] row_banks;
    logic                             found;
    logic [BANK_W-1:0]                pick;
    logic                             unused_addr;

    sel_state_e        state_d, state_q;
    logic [BANK_W-1:0] bank_d, bank_q;

    assign region      = req_addr[REGION_LSB +: REGION_W];
    assign row_idx     = region[REGION_W-1 -: ROW_W];
    assign home_slot   = region[BANK_W-1:0];
    assign unused_addr = ^(req_addr & ~REGION_MASK);

    bsel_row_rom #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .ROW_W     (ROW_W),
        .TBL_W     (TBL_W),
        .TABLE     (TABLE)
    ) rom_i (
        .row_idx   (row_idx),
        .row_banks (row_banks)
    );

    bsel_ring_pick #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) pick_i (
        .row_banks (row_banks),
        .home_slot (home_slot),
        .active    (req_active),
        .found     (found),
        .bank      (pick)
    );

    // Next-state selection
    always_comb begin
        if (!req_vld) begin
            state_d = ST_IDLE;
            bank_d  = '0;
        end else if (found) begin
            state_d = ST_HIT;
            bank_d  = pick;
        end else begin
            state_d = ST_EMPTY;
            bank_d  = '0;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bank_q  <= '0;
        end else begin
            state_q <= state_d;
            bank_q  <= bank_d;
        end
    end

    // Outputs
    always_comb begin
        rsp_vld  = 1'b0;
        rsp_hit  = 1'b0;
        rsp_bank = '0;
        unique case (state_q)
            ST_IDLE: begin
                rsp_vld  = 1'b0;
            end
            ST_HIT: begin
                rsp_vld  = 1'b1;
                rsp_hit  = 1'b1;
                rsp_bank = bank_q;
            end
            ST_EMPTY: begin
                rsp_vld  = 1'b1;
            end
            default: begin
                rsp_vld  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bsel_checker.sv
module bsel_checker #(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_vld,
    input logic [NUM_BANKS-1:0] req_active,
    input logic                 rsp_vld,
    input logic                 rsp_hit,
    input logic [BANK_W-1:0]    rsp_bank
);
    logic [NUM_BANKS-1:0] act_q;

    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= req_active;
    end

    a_r5_req_gives_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);

    a_r5_no_req_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld);

    a_r6_empty_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_active == '0) |=> (rsp_vld && !rsp_hit && rsp_bank == '0));

    a_r3_some_bank_found: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_active != '0) |=> rsp_hit);

    a_r4_bank_powered: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> act_q[rsp_bank]);

    a_r7_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_vld |-> (!rsp_hit && rsp_bank == '0));
endmodule

bind bank_steer_top bsel_checker #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vld    (req_vld),
    .req_active (req_active),
    .rsp_vld    (rsp_vld),
    .rsp_hit    (rsp_hit),
    .rsp_bank   (rsp_bank)
);

// File: tb/bank_steer_top_tb_top.sv
module bank_steer_top_tb_top;
    localparam int NB  = 8;
    localparam int BW  = 3;
    localparam int NR  = 32;
    localparam int AW  = 40;
    localparam int LSB = 6;
    localparam int TW  = NR * NB * BW;

    function automatic logic [TW-1:0] make_tb_table();
        logic [TW-1:0] t;
        t = '0;
        for (int r = 0; r < NR; r++) begin
            for (int s = 0; s < NB; s++) begin
                int v;
                v = (((s * 5) + (r * 3)) ^ (r >> 2)) % NB;
                t[(r * NB + s) * BW +: BW] = BW'(v);
            end
        end
        return t;
    endfunction

    localparam logic [TW-1:0] TB_TABLE = make_tb_table();

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          req_vld;
    logic [AW-1:0] req_addr;
    logic [NB-1:0] req_active;
    logic          rsp_vld, rsp_hit;
    logic [BW-1:0] rsp_bank;

    logic          d_vld;
    logic [AW-1:0] d_addr;
    logic [NB-1:0] d_active;
    logic          d_rsp_vld, d_rsp_hit;
    logic [BW-1:0] d_rsp_bank;

    bank_steer_top #(
        .NUM_BANKS (NB), .NUM_ROWS (NR), .ADDR_W (AW), .REGION_LSB (LSB),
        .TABLE (TB_TABLE)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .req_vld (req_vld), .req_addr (req_addr),
        .req_active (req_active), .rsp_vld (rsp_vld), .rsp_hit (rsp_hit),
        .rsp_bank (rsp_bank)
    );

    bank_steer_top #(
        .NUM_BANKS (NB), .NUM_ROWS (NR), .ADDR_W (AW), .REGION_LSB (LSB)
    ) dut_def_i (
        .clk (clk), .rst_n (rst_n), .req_vld (d_vld), .req_addr (d_addr),
        .req_active (d_active), .rsp_vld (d_rsp_vld), .rsp_hit (d_rsp_hit),
        .rsp_bank (d_rsp_bank)
    );

    int    n_vec  = 0;
    int    n_fail = 0;
    logic  p_chk  = 1'b0;
    logic  p_vld, p_hit;
    logic [BW-1:0] p_bank;
    string p_tag;

    function automatic logic [BW:0] ref_pick(input logic [7:0] region,
                                             input logic [NB-1:0] act);
        int row, slot;
        row  = int'(region[7:3]);
        slot = int'(region[2:0]);
        for (int k = 0; k < NB; k++) begin
            logic [BW-1:0] b;
            b = TB_TABLE[(row * NB + ((slot + k) % NB)) * BW +: BW];
            if (act[b]) return {1'b1, b};
        end
        return '0;
    endfunction

    function automatic logic [BW-1:0] home_of(input logic [7:0] region);
        return TB_TABLE[(int'(region[7:3]) * NB + int'(region[2:0])) * BW +: BW];
    endfunction

    task automatic check_pending();
        if (p_chk) begin
            n_vec++;
            if (rsp_vld !== p_vld || rsp_hit !== p_hit || rsp_bank !== p_bank) begin
                n_fail++;
                $display("FAIL %s: got vld=%0b hit=%0b bank=%0d, expected vld=%0b hit=%0b bank=%0d",
                         p_tag, rsp_vld, rsp_hit, rsp_bank, p_vld, p_hit, p_bank);
            end
        end
        p_chk = 1'b0;
    endtask

    task automatic step(input logic v, input logic [AW-1:0] a,
                        input logic [NB-1:0] act, input string tag);
        logic [BW:0] r;
        @(negedge clk);
        check_pending();
        req_vld    = v;
        req_addr   = a;
        req_active = act;
        r = ref_pick(a[LSB +: 8], act);
        p_vld  = v;
        p_hit  = v & r[BW];
        p_bank = v ? r[BW-1:0] : '0;
        p_tag  = tag;
        p_chk  = 1'b1;
    endtask

    function automatic logic [AW-1:0] rand_addr(input logic [7:0] region);
        logic [AW-1:0] a;
        a = {$urandom, $urandom};
        a[LSB +: 8] = region;
        return a;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] seed_sink;
        seed_sink  = 8'($urandom(32'd20240611));
        rst_n      = 1'b0;
        req_vld    = 1'b1;
        req_addr   = '0;
        req_active = '1;
        d_vld      = 1'b0;
        d_addr     = '0;
        d_active   = '1;

        // R8: requests during reset are not answered
        repeat (3) begin
            @(negedge clk);
            n_vec++;
            if (rsp_vld !== 1'b0 || rsp_hit !== 1'b0 || rsp_bank !== '0) begin
                n_fail++;
                $display("FAIL R8: got vld=%0b hit=%0b bank=%0d, expected 0 0 0",
                         rsp_vld, rsp_hit, rsp_bank);
            end
        end
        req_vld = 1'b0;
        rst_n   = 1'b1;

        // R7: idle after reset
        step(1'b0, '0, '1, "R7");
        step(1'b0, '0, '1, "R7");

        // R6: empty power vector, several regions
        for (int i = 0; i < 8; i++) begin
            step(1'b1, rand_addr(8'(i * 37)), '0, "R6");
        end
        step(1'b0, '0, '0, "R7");

        // R2/R3: every region under every non-empty vector
        for (int act = 1; act < 256; act++) begin
            for (int reg_id = 0; reg_id < 256; reg_id++) begin
                logic [NB-1:0] av;
                av = NB'(act);
                if (av[home_of(8'(reg_id))])
                    step(1'b1, rand_addr(8'(reg_id)), av, "R2");
                else
                    step(1'b1, rand_addr(8'(reg_id)), av, "R3");
            end
        end

        // R1/R5/R7: random traffic with gaps and noise outside the region field
        for (int i = 0; i < 3000; i++) begin
            logic v;
            v = ($urandom % 4) != 0;
            step(v, {$urandom, $urandom}, NB'($urandom), v ? "R1" : "R7");
        end
        step(1'b0, '0, '0, "R7");
        @(negedge clk);
        check_pending();

        // R9: default table rows are full permutations
        for (int r = 0; r < NR; r++) begin
            logic [NB-1:0] seen;
            seen = '0;
            for (int s = 0; s < NB; s++) begin
                @(negedge clk);
                d_vld  = 1'b1;
                d_addr = rand_addr(8'((r << 3) | s));
                @(negedge clk);
                d_vld = 1'b0;
                n_vec++;
                if (d_rsp_vld !== 1'b1 || d_rsp_hit !== 1'b1) begin
                    n_fail++;
                    $display("FAIL R9: got vld=%0b hit=%0b, expected 1 1", d_rsp_vld, d_rsp_hit);
                end
                seen[d_rsp_bank] = 1'b1;
            end
            n_vec++;
            if (seen !== '1) begin
                n_fail++;
                $display("FAIL R9: row %0d got bank set %b, expected %b", r, seen, {NB{1'b1}});
            end
        end

        finish_run();
    end
endmodule